// File: doc/BRIEF.md
# Recursive Split-Operand Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns their full 2N-bit product. Internally it is recursive. Each operand is split into a high half and a low half. Four half-width multipliers form the four cross products, and the recursion ends in a 2x2 cell built from AND gates and two half adders.

At each level the four partial products are lined up by concatenation rather than by shifters. The high-by-high product is placed directly above the low-by-low product. The two mixed products are padded with N/2 zero bits. The three resulting terms are reduced by a single carry-save row, and one carry-propagate add follows. The lowest N/2 bits of the low-by-low product never enter that adder and form the bottom of the result.

The arithmetic is purely combinational. The top module adds one output register with a synchronous active-high reset, so the product appears one clock after the operands are presented. N must be a power of two from 2 to 32.

Top module: `vmul_top`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `product` becomes all zeros at that edge.
- R2: When `rst` is low at a rising edge, `product` holds the unsigned product of the `a` and `b` values sampled at that edge, as a full 2N-bit value, from that edge until the next one.
- R3: If either operand sampled at an edge is zero, `product` after that edge is zero.
- R4: If both operands are all ones, `product` after the edge is (2^N-1)^2. Bit by bit from the MSB, this is N-1 ones, a zero, N-1 zeros and a one.
- R5: If one operand is the value 1, `product` after the edge equals the other operand, zero-extended to 2N bits.
- R6: Exchanging `a` and `b` leaves `product` unchanged.
- R7: The parameter N accepts any power of two from 2 to 32. At N=32 the product is exact, including values whose cross-product sums carry across the N/2 and N bit boundaries.
- R8: Bits N/2-1..0 of `product` equal the low N/2 bits of the product of the low halves of `a` and `b`, whatever the high halves hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier |
| product | output | 2N | Registered unsigned product a*b |

## Verification
The hardest case to reach is a carry-save merge whose carries ripple through the full upper part of the adder. This happens when the two mixed products and the high-by-high product all sit near their maximum together. At 32 bits random operands almost never produce it.

The bench therefore sweeps every operand pair of an 8-bit instance, which covers every such carry pattern at that width. A 32-bit instance runs alongside it, fed with random values plus directed operands: all ones, single top bits, and halves of all ones set against each other, so that the wide adder sees the same pressure at its own boundaries.

// File: rtl/vmul_pkg.sv
`timescale 1ns/1ps
package vmul_pkg;
  localparam int MIN_WIDTH = 2;
  localparam int MAX_WIDTH = 32;

  function automatic bit width_ok(input int n);
    return (n >= MIN_WIDTH) && (n <= MAX_WIDTH) && ((n & (n - 1)) == 0);
  endfunction

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/vmul_half_add.sv
`timescale 1ns/1ps
module vmul_half_add (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

// File: rtl/vmul_cell2.sv
`timescale 1ns/1ps
module vmul_cell2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic t00, t01, t10, t11;
  logic s1, c1, s2, c2;

  assign t00 = a[0] & b[0];
  assign t01 = a[0] & b[1];
  assign t10 = a[1] & b[0];
  assign t11 = a[1] & b[1];

  vmul_half_add u_ha_mid (.x(t01), .y(t10), .s(s1), .c(c1));
  vmul_half_add u_ha_top (.x(t11), .y(c1),  .s(s2), .c(c2));

  assign p = {c2, s2, s1, t00};
endmodule

// File: rtl/vmul_csa.sv
`timescale 1ns/1ps
module vmul_csa #(
  parameter int W = 6
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry_sh
);
  import vmul_pkg::*;

  assign carry_sh[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = x[i] ^ y[i] ^ z[i];
    if (i < W - 1) begin : g_cy
      assign carry_sh[i+1] = maj3(x[i], y[i], z[i]);
    end
  end
endmodule

// File: rtl/vmul_core.sv
`timescale 1ns/1ps
module vmul_core #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  if (N == 2) begin : g_leaf
    vmul_cell2 u_cell (.a(a), .b(b), .p(p));
  end else begin : g_split
    localparam int H = N / 2;
    localparam int W = 3 * H;

    logic [N-1:0] p_ll, p_hl, p_lh, p_hh;
    logic [W-1:0] op_top, op_x, op_y, s_vec, c_vec, merged;

    vmul_core #(.N(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(p_ll));
    vmul_core #(.N(H)) u_hl (.a(a[N-1:H]), .b(b[H-1:0]), .p(p_hl));
    vmul_core #(.N(H)) u_lh (.a(a[H-1:0]), .b(b[N-1:H]), .p(p_lh));
    vmul_core #(.N(H)) u_hh (.a(a[N-1:H]), .b(b[N-1:H]), .p(p_hh));

    assign op_top = {p_hh, p_ll[N-1:H]};
    assign op_x   = {{H{1'b0}}, p_hl};
    assign op_y   = {{H{1'b0}}, p_lh};

    vmul_csa #(.W(W)) u_csa (
      .x(op_top), .y(op_x), .z(op_y), .sum(s_vec), .carry_sh(c_vec)
    );

    assign merged = s_vec + c_vec;
    assign p      = {merged, p_ll[H-1:0]};
  end
endmodule

// File: rtl/vmul_top.sv
`timescale 1ns/1ps
module vmul_top #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] product
);
  import vmul_pkg::*;

  localparam int PW = 2 * N;

  if (!width_ok(N)) begin : g_bad_width
    $error("vmul_top: N must be a power of two between 2 and 32");
  end

  logic [PW-1:0] comb_p;

  vmul_core #(.N(N)) u_core (.a(a), .b(b), .p(comb_p));

  always_ff @(posedge clk) begin
    if (rst) product <= '0;
    else     product <= comb_p;
  end
endmodule

// File: rtl/vmul_check.sv
`timescale 1ns/1ps
module vmul_check #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic [2*N-1:0] product
);
  localparam int H = N / 2;
  localparam logic [2*N-1:0] ONES_SQ =
    {{(N-1){1'b1}}, 1'b0, {(N-1){1'b0}}, 1'b1};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> product == '0);

  p_product_match_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> product == ({{N{1'b0}}, $past(a)} * {{N{1'b0}}, $past(b)}));

  p_zero_operand_r3: assert property (@(posedge clk) disable iff (rst)
    (a == '0 || b == '0) |=> product == '0);

  p_all_ones_r4: assert property (@(posedge clk) disable iff (rst)
    (a == '1 && b == '1) |=> product == ONES_SQ);

  p_unit_operand_r5: assert property (@(posedge clk) disable iff (rst)
    (b == N'(1)) |=> product == {{N{1'b0}}, $past(a)});

  p_low_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> product[H-1:0] ==
      H'({{H{1'b0}}, $past(a[H-1:0])} * {{H{1'b0}}, $past(b[H-1:0])}));
endmodule

bind vmul_top vmul_check #(.N(N)) u_vmul_check (
  .clk(clk), .rst(rst), .a(a), .b(b), .product(product)
);

// File: tb/vmul_top_test.sv
`timescale 1ns/1ps
module vmul_top_test;
  localparam int NS = 8;
  localparam int NW = 32;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0]   a = '0, b = '0;
  logic [NW-1:0]   wa = '0, wb = '0;
  logic [2*NS-1:0] product;
  logic [2*NW-1:0] wproduct;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vmul_top #(.N(NS)) uut (.clk(clk), .rst(rst), .a(a), .b(b), .product(product));
  vmul_top #(.N(NW)) uut_wide (.clk(clk), .rst(rst), .a(wa), .b(wb), .product(wproduct));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] wmul(input logic [31:0] x, input logic [31:0] y);
    return {32'b0, x} * {32'b0, y};
  endfunction

  task automatic wide_case(input logic [31:0] x, input logic [31:0] y);
    wa = x; wb = y;
    @(negedge clk);
    chk("R7 wide directed", wproduct, wmul(x, y));
  endtask

  initial begin
    logic [15:0] first;
    logic [15:0] ones_sq;
    a = 8'hA5; b = 8'h3C; wa = 32'hDEAD_BEEF; wb = 32'h1234_5678;
    repeat (2) @(negedge clk);
    chk("R1 reset narrow", 64'(product), 64'h0);
    chk("R1 reset wide", wproduct, 64'h0);
    rst = 1'b0;

    ones_sq = {7'h7F, 1'b0, 7'h00, 1'b1};
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        a = 8'(i); b = 8'(j);
        wa = $urandom; wb = $urandom;
        @(negedge clk);
        if (i == 0 || j == 0)       chk("R3 zero operand", 64'(product), 64'h0);
        else if (i == 255 && j == 255) chk("R4 all ones", 64'(product), 64'(ones_sq));
        else if (j == 1)            chk("R5 unit b", 64'(product), 64'(i));
        else if (i == 1)            chk("R5 unit a", 64'(product), 64'(j));
        else                        chk("R2 exhaustive", 64'(product), 64'(i * j));
        chk("R8 low bypass", 64'(product[3:0]), 64'(((i % 16) * (j % 16)) % 16));
        chk("R7 wide random", wproduct, wmul(wa, wb));
      end
    end

    // R6: swapped operands give the same product
    for (int k = 0; k < 64; k++) begin
      logic [7:0] x, y;
      x = 8'($urandom); y = 8'($urandom);
      a = x; b = y;
      @(negedge clk);
      first = product;
      a = y; b = x;
      @(negedge clk);
      chk("R6 swap", 64'(product), 64'(first));
    end

    // R8: high halves change, low halves fixed
    a = 8'h07; b = 8'h0B;
    @(negedge clk);
    first = product;
    a = 8'hF7; b = 8'h9B;
    @(negedge clk);
    chk("R8 high halves ignored in low bits", 64'(product[3:0]), 64'(first[3:0]));

    // R7: carries across the half and full boundaries at N=32
    wide_case(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wide_case(32'hFFFF_0000, 32'h0000_FFFF);
    wide_case(32'h8000_0000, 32'h8000_0000);
    wide_case(32'h0000_FFFF, 32'hFFFF_FFFF);
    wide_case(32'hFFFF_FFFF, 32'h0000_0001);
    wide_case(32'h0001_0001, 32'hFFFF_FFFF);
    wide_case(32'h0000_0000, 32'hFFFF_FFFF);

    // R1: reset in mid-run
    a = 8'hFF; b = 8'hFF; wa = 32'hFFFF_FFFF; wb = 32'h7; rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset narrow", 64'(product), 64'h0);
    chk("R1 mid-run reset wide", wproduct, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 after reset release", 64'(product), 64'(ones_sq));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule